// File: doc/BRIEF.md
# Hamming-Coded Spread-Spectrum Baseband Link

This block protects short data words with a single-error-correcting code and then spreads every code bit over several chips of a pseudo-noise sequence. On the send side, a 7-bit word is taken through a valid/ready handshake and expanded into an 11-bit positional Hamming codeword with even parity. The codeword then leaves as a serial chip stream, one chip per clock. A start marker goes out alongside the first chip of each frame.

The receive side takes a serial chip stream and a start marker. Both ends restart an identical 7-bit maximal-length LFSR at the frame start, so their chips stay aligned. The receiver removes the spreading and decides each code bit by majority vote over its chips. It then computes the syndrome, repairs a single wrong code bit, and presents the 7 data bits with two flags: one for a correction and one for an uncorrectable pattern. The two halves are independent, so they can be looped back or wired to separate links.

Top module: `dsss_hamming_link`

## Requirements
- R1: While reset is held and right after it, in_ready is 1 and out_valid, tx_chip and tx_sof are 0.
- R2: Data bit d0 sits at code position 3, then d1..d6 at positions 5, 6, 7, 9, 10 and 11. The parity bit at position 1, 2, 4 or 8 makes the XOR of every position whose number has that bit set equal to zero (even parity).
- R3: A frame sends code positions 11 down to 1, with 7 chips per position, in the 77 cycles after the accepting edge. Each chip is the code bit XOR the PN bit, and tx_sof is 1 for the first chip only.
- R4: The PN bit is bit 6 of a 7-bit state. The state is set to 7'b0000001 at frame start and steps once per chip to {s[5:0], s[6]^s[5]}.
- R5: A word is taken on an edge where in_valid and in_ready are both 1. in_ready stays 0 for all 77 chip cycles, so a word offered during a frame starts nothing.
- R6: The receiver XORs each chip with its own PN bit and decides a code bit as 1 when at least 4 of its 7 results are 1. Up to 3 flipped chips per bit therefore leave the output unchanged.
- R7: The syndrome {r8,r4,r2,r1} is the XOR of the position numbers of all received 1 bits. A value of 1 to 11 inverts that position and sets out_fixed. A value of 0 sets no flag.
- R8: A syndrome of 12 to 15 sets out_uncorr, clears out_fixed, and leaves the data as received.
- R9: rx_sof marks the first chip of a receive frame. out_valid is a one-cycle pulse in the cycle after the edge that samples the 77th chip.
- R10: Chips that arrive with no preceding rx_sof are ignored and produce no out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Sender idle, word can be taken |
| in_data | input | 7 | Data word to send |
| tx_chip | output | 1 | Serial chip out |
| tx_sof | output | 1 | High during the first chip of a sent frame |
| rx_chip | input | 1 | Serial chip in |
| rx_sof | input | 1 | High during the first received chip of a frame |
| out_valid | output | 1 | Decoded word pulse |
| out_data | output | 7 | Decoded data bits |
| out_fixed | output | 1 | A single code bit was corrected |
| out_uncorr | output | 1 | Syndrome outside the codeword range |

## Verification
All 128 data words are sent through a loopback with no errors. This checks the chip stream against an arithmetic model of the code and the PN sequence, and it checks the decoded word. A sweep then inverts every single code position for several words, which shows that the syndrome names the right position. Patterns with three wrong chips in every bit separate correct majority voting from threshold mistakes, while four wrong chips show that a whole bit flips. Double-position errors chosen to give syndromes of 12 and above, a frame with its start marker suppressed, and a word held during a busy frame cover the flag, the ignore rule and the handshake.

// File: rtl/dsss_link_pkg.sv
package dsss_link_pkg;
  localparam int DATA_W = 7;
  localparam int CODE_W = 11;
  localparam int SYN_W  = 4;

  function automatic logic is_check_pos(input int p);
    return ((p & (p - 1)) == 0);
  endfunction

  // index p-1 holds position p
  function automatic logic [CODE_W-1:0] ham_encode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_check_pos(p)) begin
        c[p-1] = d[k];
        k++;
      end
    end
    for (int b = 0; b < SYN_W; b++) begin
      for (int p = 1; p <= CODE_W; p++) begin
        if (((p >> b) & 1) == 1 && p != (1 << b)) c[(1 << b) - 1] = c[(1 << b) - 1] ^ c[p-1];
      end
    end
    return c;
  endfunction

  function automatic logic [SYN_W-1:0] ham_syndrome(input logic [CODE_W-1:0] c);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (c[p-1]) s = s ^ SYN_W'(p);
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] ham_extract(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_check_pos(p)) begin
        d[k] = c[p-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/dsss_pn_gen.sv
module dsss_pn_gen #(
  parameter int unsigned       W     = 7,
  parameter logic [W-1:0]      TAPS  = 7'b1100000,
  parameter logic [W-1:0]      SEED  = 7'b0000001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic pn_bit
);
  logic [W-1:0] state;
  logic [W-1:0] base;

  function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  assign base   = restart ? SEED : state;
  assign pn_bit = base[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= SEED;
    else if (advance) state <= lfsr_next(base);
    else if (restart) state <= SEED;
  end
endmodule

// File: rtl/dsss_tx.sv
module dsss_tx
  import dsss_link_pkg::*;
#(
  parameter int unsigned CHIPS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              tx_chip,
  output logic              tx_sof,
  output logic              accept
);
  localparam int CHIP_W = (CHIPS > 1) ? $clog2(CHIPS) : 1;
  localparam int IDX_W  = $clog2(CODE_W);

  logic              busy;
  logic [CODE_W-1:0] cw;
  logic [IDX_W-1:0]  bit_idx;
  logic [CHIP_W-1:0] chip_cnt;
  logic              pn;
  logic              last_chip;

  assign in_ready  = !busy;
  assign accept    = in_valid && !busy;
  assign last_chip = (chip_cnt == CHIP_W'(CHIPS - 1));

  dsss_pn_gen u_pn (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(accept),
    .advance(busy),
    .pn_bit (pn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cw       <= '0;
      bit_idx  <= '0;
      chip_cnt <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      cw       <= ham_encode(in_data);
      bit_idx  <= IDX_W'(CODE_W - 1);
      chip_cnt <= '0;
    end else if (busy) begin
      if (last_chip) begin
        chip_cnt <= '0;
        if (bit_idx == '0) busy <= 1'b0;
        else               bit_idx <= bit_idx - 1'b1;
      end else begin
        chip_cnt <= chip_cnt + 1'b1;
      end
    end
  end

  assign tx_chip = busy && (cw[bit_idx] ^ pn);
  assign tx_sof  = busy && (bit_idx == IDX_W'(CODE_W - 1)) && (chip_cnt == '0);
endmodule

// File: rtl/dsss_ham_decoder.sv
module dsss_ham_decoder
  import dsss_link_pkg::*;
(
  input  logic [CODE_W-1:0] word,
  output logic [SYN_W-1:0]  syn,
  output logic [DATA_W-1:0] data,
  output logic              fixed,
  output logic              uncorr
);
  logic [CODE_W-1:0] repaired;

  always_comb begin
    syn      = ham_syndrome(word);
    fixed    = (syn != '0) && (int'(syn) <= CODE_W);
    uncorr   = (int'(syn) > CODE_W);
    repaired = word;
    for (int p = 1; p <= CODE_W; p++) begin
      if (fixed && int'(syn) == p) repaired[p-1] = ~word[p-1];
    end
    data = ham_extract(repaired);
  end
endmodule

// File: rtl/dsss_rx.sv
module dsss_rx
  import dsss_link_pkg::*;
#(
  parameter int unsigned CHIPS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_chip,
  input  logic              rx_sof,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fixed,
  output logic              out_uncorr,
  output logic              frame_done,
  output logic [SYN_W-1:0]  dec_syn
);
  localparam int CHIP_W = (CHIPS > 1) ? $clog2(CHIPS) : 1;
  localparam int ONES_W = $clog2(CHIPS + 1);
  localparam int IDX_W  = $clog2(CODE_W);
  localparam int MAJ    = CHIPS / 2 + 1;

  logic              busy;
  logic [CHIP_W-1:0] chip_cnt;
  logic [ONES_W-1:0] ones;
  logic [IDX_W-1:0]  bit_cnt;
  logic [CODE_W-1:0] shreg;
  logic              take, pn, chip_d, bit_end, decided;
  logic [CHIP_W-1:0] cur_chip;
  logic [ONES_W-1:0] cur_ones;
  logic [IDX_W-1:0]  cur_bit;
  logic [CODE_W-1:0] word;
  logic [DATA_W-1:0] dec_data;
  logic              dec_fixed, dec_uncorr;

  assign take     = rx_sof || busy;
  assign chip_d   = rx_chip ^ pn;
  assign cur_chip = rx_sof ? '0 : chip_cnt;
  assign cur_ones = (rx_sof ? '0 : ones) + ONES_W'(chip_d);
  assign cur_bit  = rx_sof ? '0 : bit_cnt;
  assign bit_end  = take && (cur_chip == CHIP_W'(CHIPS - 1));
  assign decided  = (cur_ones >= ONES_W'(MAJ));
  assign frame_done = bit_end && (cur_bit == IDX_W'(CODE_W - 1));
  assign word     = {shreg[CODE_W-2:0], decided};

  dsss_pn_gen u_pn (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(rx_sof),
    .advance(take),
    .pn_bit (pn)
  );

  dsss_ham_decoder u_dec (
    .word  (word),
    .syn   (dec_syn),
    .data  (dec_data),
    .fixed (dec_fixed),
    .uncorr(dec_uncorr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      chip_cnt <= '0;
      ones     <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
    end else if (take) begin
      if (bit_end) begin
        chip_cnt <= '0;
        ones     <= '0;
        shreg    <= word;
        bit_cnt  <= cur_bit + 1'b1;
        if (frame_done) busy <= 1'b0;
        else            busy <= 1'b1;
      end else begin
        busy     <= 1'b1;
        chip_cnt <= cur_chip + 1'b1;
        ones     <= cur_ones;
        bit_cnt  <= cur_bit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_fixed  <= 1'b0;
      out_uncorr <= 1'b0;
    end else begin
      out_valid <= frame_done;
      if (frame_done) begin
        out_data   <= dec_data;
        out_fixed  <= dec_fixed;
        out_uncorr <= dec_uncorr;
      end
    end
  end
endmodule

// File: rtl/dsss_hamming_link.sv
module dsss_hamming_link
  import dsss_link_pkg::*;
#(
  parameter int unsigned CHIPS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              tx_chip,
  output logic              tx_sof,
  input  logic              rx_chip,
  input  logic              rx_sof,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fixed,
  output logic              out_uncorr
);
  logic             tx_accept;
  logic             rx_frame_done;
  logic [SYN_W-1:0] rx_syn;

  dsss_tx #(.CHIPS(CHIPS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_data (in_data),
    .tx_chip (tx_chip),
    .tx_sof  (tx_sof),
    .accept  (tx_accept)
  );

  dsss_rx #(.CHIPS(CHIPS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_chip   (rx_chip),
    .rx_sof    (rx_sof),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_fixed (out_fixed),
    .out_uncorr(out_uncorr),
    .frame_done(rx_frame_done),
    .dec_syn   (rx_syn)
  );
endmodule

// File: rtl/dsss_link_checker.sv
module dsss_link_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       tx_sof,
  input logic       out_valid,
  input logic       out_fixed,
  input logic       out_uncorr,
  input logic       frame_done,
  input logic [3:0] syn
);
  assert_accept_starts_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (tx_sof && !in_ready));

  assert_sof_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |=> !tx_sof);

  assert_valid_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> out_valid);

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_high_syndrome_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && syn >= 4'd12) |=> (out_uncorr && !out_fixed));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_fixed && out_uncorr));
endmodule

bind dsss_hamming_link dsss_link_checker u_link_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .tx_sof    (tx_sof),
  .out_valid (out_valid),
  .out_fixed (out_fixed),
  .out_uncorr(out_uncorr),
  .frame_done(rx_frame_done),
  .syn       (rx_syn)
);

// File: tb/dsss_hamming_link_bench.sv
module dsss_hamming_link_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [6:0] in_data = '0;
  logic       in_ready, tx_chip, tx_sof, out_valid, out_fixed, out_uncorr;
  logic [6:0] out_data;
  logic       flip = 1'b0;
  logic       sof_block = 1'b0;
  logic       rx_chip, rx_sof;
  int         n_checks = 0;
  int         n_errors = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  assign rx_chip = tx_chip ^ flip;
  assign rx_sof  = tx_sof & ~sof_block;

  always #2 clk = ~clk;

  dsss_hamming_link u_dsss_hamming_link (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .tx_chip(tx_chip), .tx_sof(tx_sof), .rx_chip(rx_chip), .rx_sof(rx_sof),
    .out_valid(out_valid), .out_data(out_data), .out_fixed(out_fixed), .out_uncorr(out_uncorr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  // model: code bit at position p stored at index p-1
  function automatic logic [10:0] model_code(input logic [6:0] d);
    logic [10:0] w;
    int k = 0;
    w = '0;
    for (int p = 1; p <= 11; p++)
      if ((p & (p - 1)) != 0) begin w[p-1] = d[k]; k++; end
    for (int pw = 1; pw <= 8; pw = pw * 2) begin
      logic par = 1'b0;
      for (int p = 1; p <= 11; p++)
        if ((p & pw) != 0 && p != pw) par ^= w[p-1];
      w[pw-1] = par;
    end
    return w;
  endfunction

  function automatic logic [6:0] model_data(input logic [10:0] w);
    logic [6:0] d;
    int k = 0;
    d = '0;
    for (int p = 1; p <= 11; p++)
      if ((p & (p - 1)) != 0) begin d[k] = w[p-1]; k++; end
    return d;
  endfunction

  // mask bit k flips chip k; chip k belongs to position 11 - k/7
  task automatic run_frame(input logic [6:0] d, input logic [76:0] mask,
                           input bit block, input bit hold, input string tag);
    logic [10:0] cw, rw;
    logic [76:0] exp_chip;
    logic [6:0]  st;
    logic [3:0]  syn;
    int          bad_chip = 0, bad_sof = 0, bad_rdy = 0, bad_val = 0;
    bit          e_fix, e_unc;
    cw = model_code(d);
    st = 7'b0000001;
    for (int k = 0; k < 77; k++) begin
      exp_chip[k] = cw[10 - k / 7] ^ st[6];
      st = {st[5:0], st[6] ^ st[5]};
    end
    rw = cw;
    for (int p = 1; p <= 11; p++) begin
      int cnt = 0;
      for (int c = 0; c < 7; c++) cnt += int'(mask[(11 - p) * 7 + c]);
      if (cnt >= 4) rw[p-1] = ~rw[p-1];
    end
    syn = '0;
    for (int p = 1; p <= 11; p++) if (rw[p-1]) syn ^= 4'(p);
    e_fix = (syn != 0) && (syn <= 11);
    e_unc = (syn >= 12);
    if (e_fix) rw[syn-1] = ~rw[syn-1];

    sof_block = block;
    in_data   = d;
    in_valid  = 1'b1;
    chk(in_ready === 1'b1, {"R5 ready before ", tag}, int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    if (hold) in_data = ~d; else in_valid = 1'b0;
    for (int k = 0; k < 77; k++) begin
      flip = mask[k];
      if (tx_chip !== exp_chip[k]) bad_chip++;
      if (tx_sof !== (k == 0)) bad_sof++;
      if (in_ready !== 1'b0) bad_rdy++;
      if (out_valid !== 1'b0) bad_val++;
      @(negedge clk);
    end
    flip = 1'b0;
    in_valid = 1'b0;
    chk(bad_chip == 0, {"R3 R4 chip stream ", tag}, bad_chip, 0);
    chk(bad_sof == 0, {"R3 sof marker ", tag}, bad_sof, 0);
    chk(bad_rdy == 0, {"R5 ready low in frame ", tag}, bad_rdy, 0);
    chk(bad_val == 0, {"R9 no early valid ", tag}, bad_val, 0);
    if (block) begin
      chk(out_valid === 1'b0, {"R10 no valid without sof ", tag}, int'(out_valid), 0);
    end else begin
      chk(out_valid === 1'b1, {"R9 valid after last chip ", tag}, int'(out_valid), 1);
      if (mask == '0) chk(out_data === d, {"R2 R6 round trip ", tag}, int'(out_data), int'(d));
      else            chk(out_data === model_data(rw), {"R6 R7 R8 data ", tag},
                          int'(out_data), int'(model_data(rw)));
      chk(out_fixed === e_fix, {"R7 fixed flag ", tag}, int'(out_fixed), int'(e_fix));
      chk(out_uncorr === e_unc, {"R8 uncorr flag ", tag}, int'(out_uncorr), int'(e_unc));
    end
    @(negedge clk);
    chk(out_valid === 1'b0, {"R9 one cycle pulse ", tag}, int'(out_valid), 0);
    if (hold) chk(tx_sof === 1'b0 && in_ready === 1'b1, {"R5 held word not taken ", tag},
                  int'(tx_sof), 0);
    sof_block = 1'b0;
  endtask

  function automatic logic [76:0] bit_mask(input int p, input int nchips);
    logic [76:0] m = '0;
    for (int c = 0; c < nchips; c++) m[(11 - p) * 7 + c * 2 % 7] = 1'b1;
    return m;
  endfunction

  initial begin
    logic [76:0] m;
    repeat (2) @(negedge clk);
    chk(in_ready === 1'b1 && tx_sof === 1'b0, "R1 reset ready/sof", int'(in_ready), 1);
    chk(out_valid === 1'b0 && tx_chip === 1'b0, "R1 reset valid/chip", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0 && tx_chip === 1'b0, "R1 after reset",
        int'(in_ready), 1);

    for (int d = 0; d < 128; d++) run_frame(7'(d), '0, 1'b0, 1'b0, "clean");

    for (int i = 0; i < 6; i++)
      for (int p = 1; p <= 11; p++)
        run_frame(7'(i * 37 + 5), bit_mask(p, 7), 1'b0, 1'b0, "single code bit");

    for (int i = 0; i < 16; i++) begin
      m = '0;
      for (int p = 1; p <= 11; p++) m |= bit_mask(p, 3);
      run_frame(7'(i * 11 + 3), m, 1'b0, 1'b0, "three chips per bit");
    end
    for (int p = 1; p <= 11; p++) run_frame(7'h5A, bit_mask(p, 4), 1'b0, 1'b0, "four chips");

    run_frame(7'h33, bit_mask(8, 7) | bit_mask(4, 7), 1'b0, 1'b0, "syn12");
    run_frame(7'h4C, bit_mask(8, 7) | bit_mask(5, 7), 1'b0, 1'b0, "syn13");
    run_frame(7'h7F, bit_mask(9, 7) | bit_mask(6, 7), 1'b0, 1'b0, "syn15");
    run_frame(7'h01, bit_mask(10, 7) | bit_mask(4, 7), 1'b0, 1'b0, "syn14");

    run_frame(7'h2D, '0, 1'b1, 1'b0, "blocked sof");
    run_frame(7'h52, '0, 1'b0, 1'b1, "held input");
    run_frame(7'h6E, '0, 1'b0, 1'b0, "after hold");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule